// File: doc/BRIEF.md
# Page Table Address Translator

The block turns a virtual address into a physical address through a small page table that lives in on-chip registers, one table for the running process. The low offset bits of the virtual address go straight through. The upper bits form the virtual page number. That number is first compared against a table-length register. When it is in range, it selects a table entry that holds a frame number and three flag bits: valid, read-allowed and write-allowed.

Each request carries an access type, read or write. One clock later the block returns a response that holds either the physical address or an access error with a cause code. Software, or a neighbouring controller, fills table entries through a single write port and sets the length through a separate load strobe. With the default parameters the virtual address is 16 bits, the page size is 1024 bytes (10 offset bits), the page number is 6 bits and the frame number is 8 bits, which gives an 18-bit physical address.

Top module: `ptw_translate`

## Requirements
- R1: After reset, rsp_valid_o is 0, the table length is 0 and every entry is invalid, so the first request returns cause 2'b01.
- R2: rsp_valid_o is 1 exactly in the cycle after a cycle with req_valid_i high, and 0 otherwise.
- R3: On a successful translation, rsp_pa_o[OFF_W-1:0] equals the offset bits req_va_i[OFF_W-1:0] of the request.
- R4: On a successful translation, rsp_pa_o[PA_W-1:OFF_W] equals the frame number held in the entry selected by the page number req_va_i[VA_W-1:OFF_W].
- R5: A page number greater than or equal to the table length gives rsp_err_o=1 and cause 2'b01 (out of bounds). This check wins over every entry check, even when the entry it would select is valid.
- R6: An in-range page whose entry has valid=0 gives rsp_err_o=1 and cause 2'b10 (invalid entry).
- R7: A valid entry gives rsp_err_o=1 and cause 2'b11 (permission) for a read (req_wr_i=0) when read-allowed is 0, or for a write (req_wr_i=1) when write-allowed is 0.
- R8: A request that passes all checks gives rsp_err_o=0 and cause 2'b00.
- R9: A table write through tbl_we_i affects requests issued from the next cycle on. A request in the same cycle as the write sees the old entry.
- R10: A length load through len_we_i affects requests issued from the next cycle on. A request in the same cycle sees the old length.
- R11: Whenever rsp_err_o is 1, rsp_pa_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request strobe |
| req_wr_i | input | 1 | Access type: 1 write, 0 read |
| req_va_i | input | VA_W | Virtual address |
| tbl_we_i | input | 1 | Table entry write strobe |
| tbl_idx_i | input | VPN_W | Entry index to write |
| tbl_valid_i | input | 1 | Valid flag written to the entry |
| tbl_rd_i | input | 1 | Read-allowed flag written to the entry |
| tbl_wr_i | input | 1 | Write-allowed flag written to the entry |
| tbl_frame_i | input | FRAME_W | Frame number written to the entry |
| len_we_i | input | 1 | Table length load strobe |
| len_i | input | VPN_W+1 | New table length (0 to 2**VPN_W) |
| rsp_valid_o | output | 1 | Response valid |
| rsp_err_o | output | 1 | Access error |
| rsp_cause_o | output | 2 | Cause: 00 none, 01 bounds, 10 invalid, 11 permission |
| rsp_pa_o | output | PA_W | Physical address, zero on error |

## Verification
Two kinds of event can land in the same cycle: a translation request, and an update of the state that request depends on (an entry write to the very index being looked up, or a length load that moves the bound across the requested page). The bench provokes both collisions on purpose. In each case it expects the response to reflect the state from before the update, and it expects the following request to reflect the new state. A random phase then mixes writes, length loads and requests freely. A behavioural model checks every response in that phase, and the model commits each update only after it has computed that cycle's expected result.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'b00,
    CAUSE_BOUNDS  = 2'b01,
    CAUSE_INVALID = 2'b10,
    CAUSE_PERM    = 2'b11
  } cause_e;

  typedef struct packed {
    logic valid;
    logic rd;
    logic wr;
  } perm_t;
endpackage

// File: rtl/ptw_table.sv
module ptw_table
  import ptw_pkg::*;
#(
  parameter int VPN_W   = 6,
  parameter int FRAME_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [VPN_W-1:0]   widx_i,
  input  perm_t              wperm_i,
  input  logic [FRAME_W-1:0] wframe_i,
  input  logic [VPN_W-1:0]   ridx_i,
  output perm_t              rperm_o,
  output logic [FRAME_W-1:0] rframe_o
);
  localparam int ENTRIES = 1 << VPN_W;

  perm_t              perm_q  [ENTRIES];
  logic [FRAME_W-1:0] frame_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic hit;
    assign hit = we_i && (widx_i == VPN_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        perm_q[g]  <= '0;
        frame_q[g] <= '0;
      end else if (hit) begin
        perm_q[g]  <= wperm_i;
        frame_q[g] <= wframe_i;
      end
    end
  end

  assign rperm_o  = perm_q[ridx_i];
  assign rframe_o = frame_q[ridx_i];

  // R9: a write is visible at the read port once its edge has passed
  p_write_lands_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (perm_q[$past(widx_i)] == $past(wperm_i)) &&
             (frame_q[$past(widx_i)] == $past(wframe_i)));
endmodule

// File: rtl/ptw_check.sv
module ptw_check
  import ptw_pkg::*;
#(
  parameter int VPN_W = 6
) (
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [VPN_W:0]   len_i,
  input  perm_t            perm_i,
  input  logic             is_wr_i,
  output cause_e           cause_o
);
  logic in_range;
  logic allowed;

  assign in_range = {1'b0, vpn_i} < len_i;
  assign allowed  = is_wr_i ? perm_i.wr : perm_i.rd;

  // bounds first, then valid, then permission
  always_comb begin
    if (!in_range)          cause_o = CAUSE_BOUNDS;
    else if (!perm_i.valid) cause_o = CAUSE_INVALID;
    else if (!allowed)      cause_o = CAUSE_PERM;
    else                    cause_o = CAUSE_NONE;
  end

  // R5: out of range never reports an entry-level cause
  always_comb begin
    if ({1'b0, vpn_i} >= len_i)
      p_bounds_first_r5: assert (cause_o == CAUSE_BOUNDS);
  end
endmodule

// File: rtl/ptw_translate.sv
module ptw_translate
  import ptw_pkg::*;
#(
  parameter int VA_W    = 16,
  parameter int OFF_W   = 10,
  parameter int FRAME_W = 8,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_wr_i,
  input  logic [VA_W-1:0]    req_va_i,
  input  logic               tbl_we_i,
  input  logic [VPN_W-1:0]   tbl_idx_i,
  input  logic               tbl_valid_i,
  input  logic               tbl_rd_i,
  input  logic               tbl_wr_i,
  input  logic [FRAME_W-1:0] tbl_frame_i,
  input  logic               len_we_i,
  input  logic [VPN_W:0]     len_i,
  output logic               rsp_valid_o,
  output logic               rsp_err_o,
  output logic [1:0]         rsp_cause_o,
  output logic [PA_W-1:0]    rsp_pa_o
);
  logic [VPN_W-1:0]   vpn;
  logic [OFF_W-1:0]   off;
  logic [VPN_W:0]     len_q;
  perm_t              ent_perm;
  logic [FRAME_W-1:0] ent_frame;
  cause_e             cause;

  logic               valid_q;
  logic               err_q;
  cause_e             cause_q;
  logic [PA_W-1:0]    pa_q;

  assign vpn = req_va_i[VA_W-1:OFF_W];
  assign off = req_va_i[OFF_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       len_q <= '0;
    else if (len_we_i) len_q <= len_i;
  end

  ptw_table #(.VPN_W(VPN_W), .FRAME_W(FRAME_W)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (tbl_we_i),
    .widx_i   (tbl_idx_i),
    .wperm_i  ('{valid: tbl_valid_i, rd: tbl_rd_i, wr: tbl_wr_i}),
    .wframe_i (tbl_frame_i),
    .ridx_i   (vpn),
    .rperm_o  (ent_perm),
    .rframe_o (ent_frame)
  );

  ptw_check #(.VPN_W(VPN_W)) u_check (
    .vpn_i   (vpn),
    .len_i   (len_q),
    .perm_i  (ent_perm),
    .is_wr_i (req_wr_i),
    .cause_o (cause)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
      pa_q    <= '0;
    end else begin
      valid_q <= req_valid_i;
      if (req_valid_i) begin
        err_q   <= (cause != CAUSE_NONE);
        cause_q <= cause;
        pa_q    <= (cause == CAUSE_NONE) ? {ent_frame, off} : '0;
      end
    end
  end

  assign rsp_valid_o = valid_q;
  assign rsp_err_o   = err_q;
  assign rsp_cause_o = cause_q;
  assign rsp_pa_o    = pa_q;

  p_rsp_follows_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_no_stray_rsp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  p_offset_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_err_o || rsp_pa_o[OFF_W-1:0] == $past(req_va_i[OFF_W-1:0])));
  p_err_zero_pa_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> (rsp_pa_o == '0));
  p_err_has_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_err_o == (rsp_cause_o != 2'b00)));
endmodule

// File: tb/tb_ptw_translate.sv
module tb_ptw_translate;
  localparam int VA_W = 16, OFF_W = 10, FRAME_W = 8;
  localparam int VPN_W = VA_W - OFF_W, PA_W = FRAME_W + OFF_W;
  localparam int ENTRIES = 1 << VPN_W;

  logic clk_i = 0, rst_ni = 0;
  logic req_valid_i = 0, req_wr_i = 0;
  logic [VA_W-1:0] req_va_i = '0;
  logic tbl_we_i = 0, tbl_valid_i = 0, tbl_rd_i = 0, tbl_wr_i = 0;
  logic [VPN_W-1:0] tbl_idx_i = '0;
  logic [FRAME_W-1:0] tbl_frame_i = '0;
  logic len_we_i = 0;
  logic [VPN_W:0] len_i = '0;
  logic rsp_valid_o, rsp_err_o;
  logic [1:0] rsp_cause_o;
  logic [PA_W-1:0] rsp_pa_o;

  always #5 clk_i = ~clk_i;

  ptw_translate #(.VA_W(VA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)) dut (.*);

  int n_tests = 0, n_fail = 0;
  int m_v[ENTRIES], m_r[ENTRIES], m_w[ENTRIES], m_f[ENTRIES];
  int m_len = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [PA_W+3:0] act, input logic [PA_W+3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one clock: expected result from pre-update model, then commit updates
  task automatic cyc(input string tag);
    logic ev, ee; logic [1:0] ec; logic [PA_W-1:0] ep;
    int vpn, off;
    ev = req_valid_i; ee = 0; ec = 2'b00; ep = '0;
    vpn = int'(req_va_i) >> OFF_W;
    off = int'(req_va_i) % (1 << OFF_W);
    if (vpn >= m_len) ec = 2'b01;
    else if (m_v[vpn] == 0) ec = 2'b10;
    else if (req_wr_i ? (m_w[vpn] == 0) : (m_r[vpn] == 0)) ec = 2'b11;
    ee = (ec != 2'b00);
    if (!ee) ep = PA_W'(m_f[vpn] * (1 << OFF_W) + off);
    if (tbl_we_i) begin
      m_v[tbl_idx_i] = tbl_valid_i; m_r[tbl_idx_i] = tbl_rd_i;
      m_w[tbl_idx_i] = tbl_wr_i;    m_f[tbl_idx_i] = int'(tbl_frame_i);
    end
    if (len_we_i) m_len = int'(len_i);
    @(posedge clk_i); @(negedge clk_i);
    if (ev) check(tag, {rsp_valid_o, rsp_err_o, rsp_cause_o, rsp_pa_o}, {1'b1, ee, ec, ep});
    else    check(tag, {rsp_valid_o, 3'b0, {PA_W{1'b0}}}, {1'b0, 3'b0, {PA_W{1'b0}}});
    req_valid_i = 0; tbl_we_i = 0; len_we_i = 0;
  endtask

  task automatic rq(input int vpn, input int off, input bit wr);
    req_valid_i = 1; req_wr_i = wr;
    req_va_i = VA_W'(vpn * (1 << OFF_W) + off);
  endtask

  task automatic wt(input int idx, input bit v, input bit r, input bit w, input int fr);
    tbl_we_i = 1; tbl_idx_i = VPN_W'(idx); tbl_valid_i = v;
    tbl_rd_i = r; tbl_wr_i = w; tbl_frame_i = FRAME_W'(fr);
  endtask

  task automatic ld(input int l);
    len_we_i = 1; len_i = (VPN_W+1)'(l);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin m_v[i] = 0; m_r[i] = 0; m_w[i] = 0; m_f[i] = 0; end
    #23; @(negedge clk_i);
    check("R1 reset valid", {rsp_valid_o, 3'b0, {PA_W{1'b0}}}, '0);
    rst_ni = 1;
    rq(0, 5, 0); cyc("R1 len zero");
    cyc("R2 idle");
    ld(8); rq(0, 1, 0); cyc("R10 same cycle len");
    rq(0, 1, 0); cyc("R6 invalid entry");
    wt(3, 1, 1, 0, 'hA5); rq(3, 'h155, 0); cyc("R9 same cycle write");
    rq(3, 'h155, 0); cyc("R4 R3 read ok");
    rq(3, 'h2AA, 1); cyc("R7 write denied");
    wt(5, 1, 0, 1, 'h3C); cyc("R2 write only");
    rq(5, 7, 0); cyc("R7 read denied");
    rq(5, 7, 1); cyc("R8 write ok");
    rq(7, 0, 0); cyc("R6 top in range");
    wt(8, 1, 1, 1, 'h11); rq(8, 0, 0); cyc("R5 at bound");
    rq(8, 0, 0); cyc("R5 bounds over valid");
    ld(9); rq(8, 9, 1); cyc("R10 old len");
    rq(8, 9, 1); cyc("R10 new len");
    ld(64); wt(63, 1, 1, 1, 'hFF); cyc("R2 load");
    rq(63, 'h3FF, 1); cyc("R3 max offset");
    rq(63, 0, 0); cyc("R4 max frame");
    wt(3, 0, 1, 1, 'h00); rq(3, 1, 0); cyc("R9 old before invalidate");
    rq(3, 1, 0); cyc("R11 invalidated");
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 2) == 0)
        wt($urandom_range(0, ENTRIES-1), 1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(0, 255));
      if ($urandom_range(0, 9) == 0) ld($urandom_range(0, ENTRIES));
      if ($urandom_range(0, 3) != 0)
        rq($urandom_range(0, ENTRIES-1), $urandom_range(0, (1 << OFF_W) - 1), 1'($urandom));
      cyc("R4 random mix");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule